// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal single-word request port and an external asynchronous static RAM. The RAM holds 16-bit words and has a separate active-low strobe for each byte. One request is accepted at a time. The controller latches the request and places the address on the pins while every strobe is inactive. It then runs a read access or a write pulse whose length comes from cycle counters. It finishes with a one-cycle acknowledge.

Every timed phase lasts max(1, ceil(t_ns / CLK_NS)) clock cycles, where t_ns is the time parameter for that phase. Reads keep write enable inactive. Writes keep output enable inactive, so the memory never drives the shared data bus while the controller does. The controller keeps driving the write data for one cycle after write enable rises and then releases the bus. A request whose byte mask is all zero never selects the memory.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready_o` is high, all five memory strobes are high, `rsp_ack_o` is low and the controller does not drive `sram_dq_io`.
- R2: `sram_addr_o` changes only while chip enable, write enable, output enable and both byte strobes are high. After a request is accepted, the address is held with all strobes high for SETUP_CYC = max(1, ceil(T_ADDR_SETUP_NS/CLK_NS)) cycles before any strobe falls.
- R3: A read holds chip enable and output enable low, and write enable high, for READ_CYC = max(1, ceil(T_ACCESS_NS/CLK_NS)) cycles. `rsp_rdata_o` takes the bus value at the end of that window.
- R4: A write holds chip enable and write enable low for WP_CYC cycles. WP_CYC comes from the larger of T_WE_PULSE_NS and T_WE_HIZ_NS + T_DATA_SETUP_NS. Output enable stays high for the whole write, and the request data is on `sram_dq_io` while write enable is low.
- R5: Byte mask bit 0 selects data bits 7:0 and the lower strobe `sram_lb_no`. Mask bit 1 selects bits 15:8 and `sram_ub_no`. While chip enable is low, each strobe is low exactly when its mask bit is set. The memory changes only on selected lanes, and read data lanes whose mask bit is clear return zero.
- R6: The controller drives `sram_dq_io` only while output enable is high. The drive starts with the write pulse. It stays on for exactly one cycle after write enable rises, with chip enable and the strobes still low, and then turns off.
- R7: `rsp_ack_o` is a one-cycle pulse. It rises SETUP_CYC+READ_CYC+1 cycles after a read is accepted and SETUP_CYC+WP_CYC+2 cycles after a write is accepted. `req_ready_o` is low from acceptance through the acknowledge cycle and high in the cycle that follows.
- R8: A request with an all-zero byte mask is acknowledged in the cycle after acceptance. Chip enable never falls and the memory is left unchanged. For a read, `rsp_rdata_o` returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; taken when `req_ready_o` is high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| req_ready_o | output | 1 | Controller idle and accepting |
| rsp_ack_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, held until the next read |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce_no | output | 1 | Memory chip enable, active low |
| sram_we_no | output | 1 | Memory write enable, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_lb_no | output | 1 | Lower byte strobe, active low |
| sram_ub_no | output | 1 | Upper byte strobe, active low |
| sram_dq_io | inout | DATA_W | Bidirectional memory data bus |

## Verification
The assertions assume that the attached memory drives the data bus only while chip enable and output enable are low and write enable is high. The stimulus keeps to this by using a bench memory model that follows that rule lane by lane. The assertions also assume that request fields matter only in the accepting cycle. The stimulus therefore raises `req_valid_i` for exactly one ready cycle and drops it while the controller is busy. The sweep writes and reads every address of a 16-word configuration under every byte mask. The timing parameters are chosen so that the setup, read and write phases each span several cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ_WAIT,
    ST_WRITE_PULSE,
    ST_WRITE_HOLD,
    ST_DONE
  } state_e;

  // cycles covering t_ns, never below one
  function automatic int unsigned cyc_of(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned READ_CYC  = 1,
  parameter int unsigned WP_CYC    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_be_any_i,
  input  logic             tmr_zero_i,
  output state_e           state_q_o,
  output state_e           state_d_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o
);

  state_e state_q, state_d;
  logic   wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (req_valid_i) state_d = req_be_any_i ? ST_SETUP : ST_DONE;
      ST_SETUP:       if (tmr_zero_i)  state_d = wr_q ? ST_WRITE_PULSE : ST_READ_WAIT;
      ST_READ_WAIT:   if (tmr_zero_i)  state_d = ST_DONE;
      ST_WRITE_PULSE: if (tmr_zero_i)  state_d = ST_WRITE_HOLD;
      ST_WRITE_HOLD:                   state_d = ST_DONE;
      ST_DONE:                         state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  // reload the phase counter on every state entry
  always_comb begin
    tmr_load_o = (state_d != state_q);
    unique case (state_d)
      ST_SETUP:       tmr_val_o = CNT_W'(SETUP_CYC - 1);
      ST_READ_WAIT:   tmr_val_o = CNT_W'(READ_CYC - 1);
      ST_WRITE_PULSE: tmr_val_o = CNT_W'(WP_CYC - 1);
      default:        tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) wr_q <= req_write_i;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_q_i,
  input  state_e            state_d_i,
  input  logic              tmr_zero_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [DATA_W-1:0] dq_out_o,
  output logic              dq_drive_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ce_no,
  output logic              we_no,
  output logic              oe_no,
  output logic              lb_no,
  output logic              ub_no
);

  localparam int unsigned LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, lane_mask;
  logic [1:0]        be_q;
  logic              ce_n_q, we_n_q, oe_n_q, lb_n_q, ub_n_q, drive_q, ack_q;
  logic              accept, access_d;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{be_q[l]}};
  end

  assign accept   = (state_q_i == ST_IDLE) && req_valid_i;
  assign access_d = (state_d_i == ST_READ_WAIT) || (state_d_i == ST_WRITE_PULSE) ||
                    (state_d_i == ST_WRITE_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
        if (!req_write_i && req_be_i == 2'b00) rdata_q <= '0;
      end
      if (state_q_i == ST_READ_WAIT && tmr_zero_i) rdata_q <= dq_in_i & lane_mask;
    end
  end

  // strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      lb_n_q  <= 1'b1;
      ub_n_q  <= 1'b1;
      drive_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ce_n_q  <= !access_d;
      we_n_q  <= (state_d_i != ST_WRITE_PULSE);
      oe_n_q  <= (state_d_i != ST_READ_WAIT);
      lb_n_q  <= !(access_d && be_q[0]);
      ub_n_q  <= !(access_d && be_q[1]);
      drive_q <= (state_d_i == ST_WRITE_PULSE) || (state_d_i == ST_WRITE_HOLD);
      ack_q   <= (state_d_i == ST_DONE);
    end
  end

  assign dq_out_o   = wdata_q;
  assign dq_drive_o = drive_q;
  assign rdata_o    = rdata_q;
  assign ack_o      = ack_q;
  assign addr_o     = addr_q;
  assign ce_no      = ce_n_q;
  assign we_no      = we_n_q;
  assign oe_no      = oe_n_q;
  assign lb_no      = lb_n_q;
  assign ub_no      = ub_n_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W          = 20,
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned CLK_NS          = 20,
  parameter int unsigned T_ADDR_SETUP_NS = 0,
  parameter int unsigned T_ACCESS_NS     = 10,
  parameter int unsigned T_WE_PULSE_NS   = 8,
  parameter int unsigned T_WE_HIZ_NS     = 4,
  parameter int unsigned T_DATA_SETUP_NS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_be_i,
  output logic              req_ready_o,
  output logic              rsp_ack_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic              sram_lb_no,
  output logic              sram_ub_no,
  inout  wire  [DATA_W-1:0] sram_dq_io
);

  localparam int unsigned SETUP_CYC = cyc_of(T_ADDR_SETUP_NS, CLK_NS);
  localparam int unsigned READ_CYC  = cyc_of(T_ACCESS_NS, CLK_NS);
  localparam int unsigned WP_CYC    = cyc_of(umax(T_WE_PULSE_NS, T_WE_HIZ_NS + T_DATA_SETUP_NS), CLK_NS);
  localparam int unsigned MAX_CYC   = umax(SETUP_CYC, umax(READ_CYC, WP_CYC));
  localparam int unsigned CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  state_e            state_q, state_d;
  logic              tmr_load, tmr_zero, dq_drive;
  logic [CNT_W-1:0]  tmr_val;
  logic [DATA_W-1:0] dq_out;

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .READ_CYC(READ_CYC), .WP_CYC(WP_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_be_any_i (|req_be_i),
    .tmr_zero_i   (tmr_zero),
    .state_q_o    (state_q),
    .state_d_o    (state_d),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val)
  );

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (state_q),
    .state_d_i   (state_d),
    .tmr_zero_i  (tmr_zero),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .dq_in_i     (sram_dq_io),
    .dq_out_o    (dq_out),
    .dq_drive_o  (dq_drive),
    .rdata_o     (rsp_rdata_o),
    .ack_o       (rsp_ack_o),
    .addr_o      (sram_addr_o),
    .ce_no       (sram_ce_no),
    .we_no       (sram_we_no),
    .oe_no       (sram_oe_no),
    .lb_no       (sram_lb_no),
    .ub_no       (sram_ub_no)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign sram_dq_io  = dq_drive ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              ack_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_n_i,
  input logic              we_n_i,
  input logic              oe_n_i,
  input logic              lb_n_i,
  input logic              ub_n_i,
  input logic              drive_i
);

  logic all_hi;
  assign all_hi = ce_n_i && we_n_i && oe_n_i && lb_n_i && ub_n_i;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (all_hi && !drive_i && !ack_i));

  // R2
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_i) |-> all_hi);

  // R4
  we_no_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> (oe_n_i && !ce_n_i));

  // R5
  ce_needs_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_i |-> (!lb_n_i || !ub_n_i));

  // R6
  drive_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |-> oe_n_i);

  // R6
  drive_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_i) |-> (drive_i && !ce_n_i));

  // R6
  drive_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_i) |=> !drive_i);

  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!ack_i && ready_i));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (req_ready_o),
  .ack_i   (rsp_ack_o),
  .addr_i  (sram_addr_o),
  .ce_n_i  (sram_ce_no),
  .we_n_i  (sram_we_no),
  .oe_n_i  (sram_oe_no),
  .lb_n_i  (sram_lb_no),
  .ub_n_i  (sram_ub_no),
  .drive_i (dq_drive)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int unsigned AW    = 4;
  localparam int unsigned DW    = 16;
  localparam int unsigned DEPTH = 1 << AW;
  // 20 ns clock; timing chosen so phases span several cycles
  localparam int unsigned SETUP_CYC = 2;  // ceil(25/20)
  localparam int unsigned READ_CYC  = 3;  // ceil(50/20)
  localparam int unsigned WP_CYC    = 2;  // ceil(max(30,4+6)/20)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          ready, ack, ce_n, we_n, oe_n, lb_n, ub_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] sram_addr;
  wire  [DW-1:0] dq;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  sram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(20), .T_ADDR_SETUP_NS(25), .T_ACCESS_NS(50),
    .T_WE_PULSE_NS(30), .T_WE_HIZ_NS(4), .T_DATA_SETUP_NS(6)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .req_ready_o(ready), .rsp_ack_o(ack), .rsp_rdata_o(rdata), .sram_addr_o(sram_addr),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n), .sram_lb_no(lb_n),
    .sram_ub_no(ub_n), .sram_dq_io(dq)
  );

  // memory model: outputs per lane only when read-enabled
  assign dq[7:0]  = (!ce_n && !oe_n && we_n && !lb_n) ? mem[sram_addr][7:0]  : 8'hzz;
  assign dq[15:8] = (!ce_n && !oe_n && we_n && !ub_n) ? mem[sram_addr][15:8] : 8'hzz;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (!ce_n && !we_n) begin
      if (!lb_n) mem[sram_addr][7:0]  <= dq[7:0];
      if (!ub_n) mem[sram_addr][15:8] <= dq[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_bits(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [1:0] be);
    int lat = 0, n_setup = 0, n_ce = 0, n_oe = 0, n_we = 0, n_hold = 0;
    int lane_bad = 0, wdata_bad = 0, oe_bad = 0, addr_bad = 0, busy_ready = 0;
    bit seen_ce = 0;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    prev_addr = sram_addr;
    forever begin
      @(negedge clk);
      lat++;
      req_valid = 1'b0;
      if (sram_addr != prev_addr && !(ce_n && we_n && oe_n && lb_n && ub_n)) addr_bad++;
      prev_addr = sram_addr;
      if (ready) busy_ready++;
      if (!seen_ce && ce_n && we_n && oe_n && lb_n && ub_n && !ack) n_setup++;
      if (!ce_n) begin
        seen_ce = 1;
        n_ce++;
        if (lb_n != !be[0] || ub_n != !be[1]) lane_bad++;
      end
      if (!oe_n) n_oe++;
      if (wr && !oe_n) oe_bad++;
      if (!we_n) begin
        n_we++;
        if (dq !== d) wdata_bad++;
      end
      if (wr && !ce_n && we_n) begin
        n_hold++;
        if (dq !== d) wdata_bad++;
      end
      if (ack || lat > 100) break;
    end
    chk(ack, "R7 ack seen", ack, 1);
    chk(addr_bad == 0, "R2 address moved under strobe", addr_bad, 0);
    chk(busy_ready == 0, "R7 ready while busy", busy_ready, 0);
    if (be == 2'b00) begin
      chk(lat == 1, "R8 zero-mask ack latency", lat, 1);
      chk(n_ce == 0, "R8 zero-mask chip enable", n_ce, 0);
      if (!wr) chk(rdata == '0, "R8 zero-mask read data", rdata, 0);
    end else if (wr) begin
      chk(lat == SETUP_CYC + WP_CYC + 2, "R7 write ack latency", lat, SETUP_CYC + WP_CYC + 2);
      chk(n_setup == SETUP_CYC, "R2 write setup cycles", n_setup, SETUP_CYC);
      chk(n_we == WP_CYC, "R4 write pulse cycles", n_we, WP_CYC);
      chk(oe_bad == 0 && n_oe == 0, "R4 output enable during write", n_oe, 0);
      chk(wdata_bad == 0, "R4 write data on bus", wdata_bad, 0);
      chk(n_hold == 1, "R6 data hold cycle after write", n_hold, 1);
      chk(lane_bad == 0, "R5 write lane strobes", lane_bad, 0);
      for (int l = 0; l < 2; l++)
        if (be[l]) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
    end else begin
      exp_rd = ref_mem[a] & lane_bits(be);
      chk(lat == SETUP_CYC + READ_CYC + 1, "R7 read ack latency", lat, SETUP_CYC + READ_CYC + 1);
      chk(n_setup == SETUP_CYC, "R2 read setup cycles", n_setup, SETUP_CYC);
      chk(n_oe == READ_CYC && n_ce == READ_CYC && n_we == 0, "R3 read window", n_oe, READ_CYC);
      chk(lane_bad == 0, "R5 read lane strobes", lane_bad, 0);
      chk(rdata == exp_rd, "R3 R5 read data", rdata, exp_rd);
    end
    @(negedge clk);
    chk(!ack && ready, "R7 ack single pulse then ready", {ack, ready}, 1);
    chk(ce_n && we_n && oe_n && lb_n && ub_n, "R1 idle strobes high", {ce_n, we_n, oe_n, lb_n, ub_n}, 5'h1f);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 16'h1357) ^ (16'hA5C3 + k * 16'h0F1D));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(ready && !ack, "R1 reset ready/ack", {ready, ack}, 2);
    chk(ce_n && we_n && oe_n && lb_n && ub_n, "R1 reset strobes", {ce_n, we_n, oe_n, lb_n, ub_n}, 5'h1f);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && ce_n, "R1 idle after reset", {ready, ce_n}, 3);

    for (int a = 0; a < DEPTH; a++) txn(1'b1, AW'(a), pat(a, 0), 2'b11);
    for (int a = 0; a < DEPTH; a++) txn(1'b0, AW'(a), '0, 2'b11);

    // every partial mask on every address
    for (int a = 0; a < DEPTH; a++) begin
      txn(1'b1, AW'(a), pat(a, 1), 2'b01);
      for (int m = 1; m < 4; m++) txn(1'b0, AW'(a), '0, 2'(m));
      txn(1'b1, AW'(a), pat(a, 2), 2'b10);
      for (int m = 1; m < 4; m++) txn(1'b0, AW'(a), '0, 2'(m));
    end

    // R8 zero mask: no access, memory untouched
    txn(1'b1, AW'(5), 16'hDEAD, 2'b00);
    txn(1'b0, AW'(5), '0, 2'b11);
    txn(1'b0, AW'(9), '0, 2'b00);
    txn(1'b1, AW'(0), 16'hBEEF, 2'b00);
    txn(1'b0, AW'(0), '0, 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule